// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast clock by an integer ratio. It does not use one wide modulo counter. Instead it switches a small dual-modulus prescaler between two moduli. The prescaler counts input clocks in cycles of either N+1 or N clocks. The mode line picks which one.

Two down-counters step once per prescaler cycle, and both start from their load values at the beginning of each output period:

- The swallow counter holds the long (N+1) modulus for the first S prescaler cycles.
- The program counter ends the output period after P prescaler cycles.

One output period therefore lasts S·(N+1) + (P−S)·N = N·P + S input clocks. With N=4, S=2 and P=12 the ratio is 50.

The settings `cfg_n`, `cfg_s` and `cfg_p` are static. They are changed while `rst` is asserted. The divided clock comes out as a single-clock pulse at every program-counter expiry. A build option adds a square wave at half the pulse rate. An illegal combination of settings raises an error flag and silences both outputs.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With legal settings, `div_pulse` is high for exactly one clock every N·P+S clocks. The first pulse is visible after the (N·P+S)-th rising edge following the release of `rst`.
- R2: In each output period the first S prescaler cycles last N+1 clocks and the remaining P−S cycles last N clocks.
- R3: The prescaler modulus changes only at a prescaler terminal count, never partway through a prescaler cycle.
- R4: The swallow counter decrements once per prescaler cycle and stops at zero; it never wraps below zero within a period.
- R5: At program-counter expiry, both counters reload from `cfg_s` and `cfg_p` in the same clock, and the next period starts with the long modulus when S>0.
- R6: `cfg_err` is 1 exactly when P ≤ S or N = 0. It follows the settings one clock later. While it is 1, `div_pulse` and `div_square` stay 0.
- R7: When `EN_SQUARE` is 1, `div_square` starts at 0 after reset and inverts on every clock in which `div_pulse` is 1. When `EN_SQUARE` is 0, `div_square` is tied to 0.
- R8: `rst` is synchronous and active high. While it is asserted, `div_pulse` and `div_square` are 0.
- R9: S = 0 is legal and gives a plain divide by N·P. N = 1 with P = 1 and S = 0 gives a pulse on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_n | input | CFG_W | Prescaler base modulus N |
| cfg_s | input | CFG_W | Swallow count S (prescaler cycles at N+1) |
| cfg_p | input | CFG_W | Program count P (prescaler cycles per output period) |
| div_pulse | output | 1 | One-clock pulse per output period |
| div_square | output | 1 | Square wave that toggles on each pulse |
| cfg_err | output | 1 | Illegal settings flag (P ≤ S or N = 0) |

## Verification
Two events collide on the last prescaler terminal count of each period:

- the program counter expires, and
- the prescaler must choose its next modulus.

At that moment the choice has to come from the reloaded swallow count, not from the exhausted one. Otherwise the second and later periods come out one clock short.

The collision is provoked with configurations where S>0, and with P = S+1, where the swallow counter runs out one prescaler cycle before the expiry. The degenerate case N=1, P=1 is also used, where every clock is both a terminal count and an expiry. A behavioural model that only counts clocks since reset judges every cycle across several consecutive periods. Any length error in a later period therefore shows up as a misplaced pulse.

// File: rtl/psd_pkg.sv
package psd_pkg;

  parameter int unsigned CFG_W = 8;

  typedef logic [CFG_W-1:0] cfg_t;

  // Count value loaded into the prescaler for a long (N+1) or short (N) cycle.
  function automatic cfg_t psd_reload(input cfg_t n, input logic long_mode);
    return long_mode ? n : cfg_t'(n - cfg_t'(1));
  endfunction

  // Decrement that saturates at zero.
  function automatic cfg_t psd_step_down(input cfg_t v);
    return (v == '0) ? '0 : cfg_t'(v - cfg_t'(1));
  endfunction

  // Settings that cannot produce a valid output period.
  function automatic logic psd_cfg_bad(input cfg_t n, input cfg_t s, input cfg_t p);
    return (n == '0) || (p <= s);
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t div_n,
  input  logic long_next,
  output logic pre_tc,
  output logic mode_long
);

  cfg_t cnt_q;
  logic mode_q;

  assign pre_tc    = (cnt_q == '0);
  assign mode_long = mode_q;

  always_ff @(posedge clk) begin
    if (rst || pre_tc) begin
      cnt_q  <= psd_reload(div_n, long_next);
      mode_q <= long_next;
    end else begin
      cnt_q  <= cfg_t'(cnt_q - cfg_t'(1));
    end
  end

  // R3: the modulus level is only re-sampled at a terminal count
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !pre_tc |=> $stable(mode_q));

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_s,
  input  logic pre_tc,
  input  logic prog_expire,
  output logic long_next
);

  cfg_t sc_q;
  cfg_t sc_nxt;

  always_comb begin
    if (rst || (pre_tc && prog_expire)) sc_nxt = cfg_s;
    else if (pre_tc)                    sc_nxt = psd_step_down(sc_q);
    else                                sc_nxt = sc_q;
  end

  assign long_next = (sc_nxt != '0);

  always_ff @(posedge clk) begin
    sc_q <= sc_nxt;
  end

  // R4: once exhausted, the swallow count stays at zero until the period ends
  a_r4_swallow_floor: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && !prog_expire && sc_q == '0) |=> (sc_q == '0));

  // R5: swallow count re-arms from the setting at program expiry
  a_r5_swallow_rearm: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && prog_expire) |=> (sc_q == $past(cfg_s)));

endmodule

// File: rtl/psd_program_ctr.sv
module psd_program_ctr
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_p,
  input  logic pre_tc,
  output logic prog_expire
);

  cfg_t pc_q;

  assign prog_expire = pre_tc && (pc_q == cfg_t'(1));

  always_ff @(posedge clk) begin
    if (rst || prog_expire) pc_q <= cfg_p;
    else if (pre_tc)        pc_q <= cfg_t'(pc_q - cfg_t'(1));
  end

  // R5: program count reloads from the setting in the expiry clock
  a_r5_prog_reload: assert property (@(posedge clk) disable iff (rst)
    prog_expire |=> (pc_q == $past(cfg_p)));

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter bit EN_SQUARE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [psd_pkg::CFG_W-1:0]     cfg_n,
  input  logic [psd_pkg::CFG_W-1:0]     cfg_s,
  input  logic [psd_pkg::CFG_W-1:0]     cfg_p,
  output logic                          div_pulse,
  output logic                          div_square,
  output logic                          cfg_err
);

  logic pre_tc;
  logic mode_long;
  logic long_next;
  logic prog_expire;
  logic cfg_bad;
  logic pulse_q;
  logic err_q;

  assign cfg_bad = psd_cfg_bad(cfg_n, cfg_s, cfg_p);

  psd_prescaler u_pre (
    .clk       (clk),
    .rst       (rst),
    .div_n     (cfg_n),
    .long_next (long_next),
    .pre_tc    (pre_tc),
    .mode_long (mode_long)
  );

  psd_swallow_ctr u_swl (
    .clk         (clk),
    .rst         (rst),
    .cfg_s       (cfg_s),
    .pre_tc      (pre_tc),
    .prog_expire (prog_expire),
    .long_next   (long_next)
  );

  psd_program_ctr u_prg (
    .clk         (clk),
    .rst         (rst),
    .cfg_p       (cfg_p),
    .pre_tc      (pre_tc),
    .prog_expire (prog_expire)
  );

  always_ff @(posedge clk) begin
    pulse_q <= !rst && prog_expire && !cfg_bad;
    err_q   <= cfg_bad;
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = err_q;

  generate
    if (EN_SQUARE) begin : g_square
      logic sq_q;
      always_ff @(posedge clk) begin
        if (rst || cfg_bad)                sq_q <= 1'b0;
        else if (prog_expire)              sq_q <= ~sq_q;
      end
      assign div_square = sq_q;
    end else begin : g_no_square
      assign div_square = 1'b0;
    end
  endgenerate

  // R6: flagged settings keep both outputs quiet
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!div_pulse && !div_square));

  // R7: the square output only moves together with a pulse
  a_r7_square_edge: assert property (@(posedge clk) disable iff (rst)
    (!$stable(div_square) && !cfg_err) |-> div_pulse);

  // R2: a new modulus is only taken at a prescaler terminal count
  a_r2_mode_at_tc: assert property (@(posedge clk) disable iff (rst)
    (!pre_tc && !mode_long) |=> !mode_long);

endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;

  localparam int W = psd_pkg::CFG_W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cfg_n = W'(4);
  logic [W-1:0] cfg_s = W'(2);
  logic [W-1:0] cfg_p = W'(12);
  logic         div_pulse;
  logic         div_square;
  logic         cfg_err;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_divider #(.EN_SQUARE(1'b1)) u_pulse_swallow_divider (
    .clk        (clk),
    .rst        (rst),
    .cfg_n      (cfg_n),
    .cfg_s      (cfg_s),
    .cfg_p      (cfg_p),
    .div_pulse  (div_pulse),
    .div_square (div_square),
    .cfg_err    (cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_reset(input int n, input int s, input int p);
    @(negedge clk);
    rst   = 1'b1;
    cfg_n = W'(n);
    cfg_s = W'(s);
    cfg_p = W'(p);
    repeat (3) @(negedge clk);
    // R8: outputs quiet while reset is held
    check(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
    check(div_square == 1'b0, "R8 square in reset", int'(div_square), 0);
    rst = 1'b0;
  endtask

  // Behavioural reference: pulse after edge k when (k+1) is a multiple of the ratio.
  task automatic run_legal(input int n, input int s, input int p, input int periods, input string req);
    int len;
    int last;
    len  = n * p + s;
    last = -1;
    apply_reset(n, s, p);
    for (int k = 0; k < periods * len + 3; k++) begin
      bit exp_p;
      bit exp_q;
      @(negedge clk);
      exp_p = ((k + 1) % len) == 0;
      exp_q = (((k + 1) / len) % 2) == 1;
      check(div_pulse == exp_p, req, int'(div_pulse), int'(exp_p));
      check(div_square == exp_q, "R7 square", int'(div_square), int'(exp_q));
      check(cfg_err == 1'b0, "R6 no error", int'(cfg_err), 0);
      if (div_pulse) begin
        if (last >= 0)
          check((k - last) == len, "R5 period after reload", k - last, len);
        last = k;
      end
    end
  endtask

  task automatic run_bad(input int n, input int s, input int p);
    apply_reset(n, s, p);
    check(cfg_err == 1'b1, "R6 flag", int'(cfg_err), 1);
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      check(!div_pulse && !div_square, "R6 silent", int'({div_pulse, div_square}), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run_legal(4, 2, 12, 3, "R1 default ratio 50");
    run_legal(2, 1, 2, 4, "R2 mixed moduli ratio 5");
    run_legal(3, 5, 6, 3, "R5 P=S+1 ratio 23");
    run_legal(7, 0, 3, 3, "R9 no swallow ratio 21");
    run_legal(1, 0, 1, 6, "R9 every clock");
    run_legal(5, 3, 4, 3, "R4 swallow floor ratio 23");
    run_legal(2, 2, 9, 3, "R3 modulus switch ratio 20");
    run_bad(4, 3, 3);
    run_bad(0, 1, 4);
    run_bad(4, 5, 2);
    // R6: settings made illegal while running, flag one clock later
    run_legal(4, 2, 12, 1, "R1 before live change");
    @(negedge clk);
    cfg_p = W'(2);
    @(negedge clk);
    check(cfg_err == 1'b1, "R6 live flag", int'(cfg_err), 1);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      check(!div_pulse && !div_square, "R6 live silent", int'({div_pulse, div_square}), 0);
    end
    run_legal(4, 2, 12, 2, "R1 recovery after error");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule